// File: doc/BRIEF.md
# Receive Frame Queue with Full-Queue Policy

This block holds complete received CAN frames until a host reads them. The frame receiver presents each finished frame with a one-cycle strobe. The frame carries an identifier, a data length code and up to eight data bytes. The block stores the frame in one of four slots. The host always sees the oldest stored frame at the read outputs, together with a message-available flag. A pop request removes that frame, and the next oldest frame moves into view.

A one-bit policy register decides what happens to a frame that arrives while every slot is occupied and no pop is taking place in the same cycle. In drop mode the frame is discarded: nothing in storage changes and the receive pulse stays low. Drop mode is the state after reset. In overwrite mode the newest slot (slot 3) is replaced by the incoming frame, and the three older frames are kept. When a pop and a frame arrive in the same cycle on a full queue, the pop is handled first, so the frame is stored normally.

Top module: `rxq_msg_queue`

## Requirements
- R1: After reset the queue is empty: `count_o` is 0, `empty_o` is 1, `full_o`, `msg_avail_o` and `rx_flag_o` are 0, and the policy register holds 0 (drop mode).
- R2: A frame strobed while the queue is not full is written into the next free slot, and `count_o` rises by one in the following cycle.
- R3: `rx_flag_o` is high for exactly the one cycle after an edge at which a frame was stored or overwrote a slot. It is low in every other cycle.
- R4: The read outputs always show the oldest stored frame. A pop on a non-empty queue removes that frame and lowers `count_o` by one, keeping first-in first-out order.
- R5: A pop while the queue is empty has no effect: the count stays 0 and no flag is raised.
- R6: With policy 0, a frame strobed into a full queue without a pop is discarded. Count and stored frames are unchanged, and `rx_flag_o` stays low.
- R7: With policy 1, a frame strobed into a full queue without a pop replaces slot 3 (the newest). The three older frames are unchanged, the count stays 4, and `rx_flag_o` pulses.
- R8: A frame and a pop in the same cycle on a full queue: the oldest frame is removed and the new frame is stored as the newest. The count stays 4 and `rx_flag_o` pulses, under either policy.
- R9: `empty_o` is 1 exactly when `count_o` is 0. `full_o` is 1 exactly when `count_o` is 4. `msg_avail_o` is the inverse of `empty_o`.
- R10: The policy register captures `cfg_ovr_i` only at an edge where `cfg_load_i` is 1. At other edges it holds its value.
- R11: A frame and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged. The new frame becomes the newest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load strobe for the full-queue policy register |
| cfg_ovr_i | input | 1 | Policy value: 1 = overwrite newest slot, 0 = drop |
| wr_valid_i | input | 1 | Frame-complete strobe |
| wr_id_i | input | 29 | Identifier of the incoming frame |
| wr_dlc_i | input | 4 | Data length code of the incoming frame |
| wr_data_i | input | 64 | Data bytes of the incoming frame |
| pop_i | input | 1 | Host request to remove the oldest frame |
| rd_id_o | output | 29 | Identifier of the oldest stored frame |
| rd_dlc_o | output | 4 | Data length code of the oldest stored frame |
| rd_data_o | output | 64 | Data bytes of the oldest stored frame |
| msg_avail_o | output | 1 | At least one frame is stored |
| rx_flag_o | output | 1 | One-cycle pulse after a frame is accepted |
| empty_o | output | 1 | No frame stored |
| full_o | output | 1 | All four slots occupied |
| count_o | output | 3 | Number of stored frames, 0 to 4 |

## Verification
A wrong count shows up at `count_o` and the status flags in the cycle after the faulty update. It then shows up again when the drained frames no longer match the order in which they were offered. A wrong slot select or shift stays hidden until the damaged slot reaches the read outputs, which can be up to three pops later. For that reason every scenario drains the queue and compares each frame in turn. A policy fault appears at `rx_flag_o` one cycle after the full-queue strobe, and later as a changed or missing newest frame during the drain.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int NBYTES = 8;
  localparam int DATA_W = NBYTES * 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rxq_frame_t;

  // Slot index a stored frame lands in, counted after any pop shift.
  function automatic int slot_for_write(int cnt, bit pop_eff, int depth);
    if (pop_eff)
      return cnt - 1;
    else if (cnt >= depth)
      return depth - 1;
    else
      return cnt;
  endfunction

  // Occupancy after one cycle.
  function automatic int next_count(int cnt, bit stored, bit pop_eff);
    return cnt + (stored ? 1 : 0) - (pop_eff ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_i,
  input  logic             cfg_ovr_i,
  input  logic             wr_valid_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic [DEPTH-1:0] wr_sel_o,
  output logic             shift_o,
  output logic             store_evt_o,
  output logic             ovr_evt_o,
  output logic             drop_evt_o,
  output logic             ovr_q_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;
  logic             is_full;
  logic             is_empty;
  logic             pop_eff;
  logic             accept;
  logic             ovr_hit;
  int               idx;

  assign is_full  = (int'(cnt_q) == DEPTH);
  assign is_empty = (cnt_q == '0);
  assign pop_eff  = pop_i && !is_empty;
  assign accept   = wr_valid_i && (!is_full || pop_eff);
  assign ovr_hit  = wr_valid_i && is_full && !pop_eff && ovr_q;

  always_comb begin
    idx      = slot_for_write(int'(cnt_q), pop_eff, DEPTH);
    wr_sel_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((accept || ovr_hit) && (idx == i)) wr_sel_o[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= CNT_W'(next_count(int'(cnt_q), accept, pop_eff));
      if (cfg_load_i) ovr_q <= cfg_ovr_i;
    end
  end

  assign count_o     = cnt_q;
  assign shift_o     = pop_eff;
  assign store_evt_o = accept;
  assign ovr_evt_o   = ovr_hit;
  assign drop_evt_o  = wr_valid_i && is_full && !pop_eff && !ovr_q;
  assign ovr_q_o     = ovr_q;

endmodule

// File: rtl/rxq_slot_array.sv
module rxq_slot_array
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] wr_sel_i,
  input  logic             shift_i,
  input  rxq_frame_t       frame_i,
  output rxq_frame_t       head_o
);

  rxq_frame_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rxq_frame_t upper;
    if (g == DEPTH - 1) begin : g_top
      assign upper = slot_q[g];
    end else begin : g_mid
      assign upper = slot_q[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_sel_i[g])
        slot_q[g] <= frame_i;
      else if (shift_i)
        slot_q[g] <= upper;
    end
  end

  assign head_o = slot_q[0];

endmodule

// File: rtl/rxq_flag_gen.sv
module rxq_flag_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic store_evt_i,
  input  logic ovr_evt_i,
  output logic rx_flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_flag_o <= 1'b0;
    else        rx_flag_o <= store_evt_i || ovr_evt_i;
  end

endmodule

// File: rtl/rxq_msg_queue.sv
module rxq_msg_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic              cfg_ovr_i,
  input  logic              wr_valid_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [DLC_W-1:0]  wr_dlc_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [DLC_W-1:0]  rd_dlc_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              msg_avail_o,
  output logic              rx_flag_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [DEPTH-1:0] wr_sel;
  logic             shift_en;
  logic             store_evt;
  logic             ovr_evt;
  logic             drop_evt;
  logic             ovr_q;
  rxq_frame_t       in_frame;
  rxq_frame_t       head;

  assign in_frame = '{id: wr_id_i, dlc: wr_dlc_i, data: wr_data_i};

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load_i  (cfg_load_i),
    .cfg_ovr_i   (cfg_ovr_i),
    .wr_valid_i  (wr_valid_i),
    .pop_i       (pop_i),
    .count_o     (count_o),
    .wr_sel_o    (wr_sel),
    .shift_o     (shift_en),
    .store_evt_o (store_evt),
    .ovr_evt_o   (ovr_evt),
    .drop_evt_o  (drop_evt),
    .ovr_q_o     (ovr_q)
  );

  rxq_slot_array #(.DEPTH(DEPTH)) slots_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel_i (wr_sel),
    .shift_i  (shift_en),
    .frame_i  (in_frame),
    .head_o   (head)
  );

  rxq_flag_gen flag_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_evt_i (store_evt),
    .ovr_evt_i   (ovr_evt),
    .rx_flag_o   (rx_flag_o)
  );

  assign rd_id_o     = head.id;
  assign rd_dlc_o    = head.dlc;
  assign rd_data_o   = head.data;
  assign empty_o     = (count_o == '0);
  assign full_o      = (int'(count_o) == DEPTH);
  assign msg_avail_o = !empty_o;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid_i,
  input logic             pop_i,
  input logic             cfg_load_i,
  input logic             cfg_ovr_i,
  input logic             ovr_q,
  input logic             drop_evt,
  input logic [DEPTH-1:0] wr_sel,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             msg_avail_o,
  input logic             rx_flag_o
);

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_o) <= DEPTH);

  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o) && (msg_avail_o != empty_o));

  // R2
  store_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !full_o && !pop_i) |=> (count_o == $past(count_o) + 1'b1) && rx_flag_o);

  // R3
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> !rx_flag_o);

  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !wr_valid_i) |=> empty_o && !rx_flag_o);

  // R6
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && full_o && !pop_i && !ovr_q) |=> !rx_flag_o && full_o);

  // R6
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (wr_sel == '0));

  // R7
  ovr_keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && full_o && !pop_i && ovr_q) |=> rx_flag_o && full_o);

  // R8
  simul_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && pop_i && full_o) |=> rx_flag_o && full_o);

  // R10
  policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_i |=> $stable(ovr_q));

  // R10
  policy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_i |=> (ovr_q == $past(cfg_ovr_i)));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

endmodule

bind rxq_msg_queue rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid_i  (wr_valid_i),
  .pop_i       (pop_i),
  .cfg_load_i  (cfg_load_i),
  .cfg_ovr_i   (cfg_ovr_i),
  .ovr_q       (ovr_q),
  .drop_evt    (drop_evt),
  .wr_sel      (wr_sel),
  .count_o     (count_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .msg_avail_o (msg_avail_o),
  .rx_flag_o   (rx_flag_o)
);

// File: tb/rxq_msg_queue_tb_top.sv
module rxq_msg_queue_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load_i, cfg_ovr_i, wr_valid_i, pop_i;
  logic [28:0] wr_id_i;
  logic [3:0]  wr_dlc_i;
  logic [63:0] wr_data_i;
  logic [28:0] rd_id_o;
  logic [3:0]  rd_dlc_o;
  logic [63:0] rd_data_o;
  logic        msg_avail_o, rx_flag_o, empty_o, full_o;
  logic [2:0]  count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int   m_cnt;
  logic [7:0] m_tag [4];
  bit   m_ovr;

  always #4 clk = ~clk;

  rxq_msg_queue dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i), .cfg_ovr_i(cfg_ovr_i),
    .wr_valid_i(wr_valid_i), .wr_id_i(wr_id_i), .wr_dlc_i(wr_dlc_i),
    .wr_data_i(wr_data_i), .pop_i(pop_i), .rd_id_o(rd_id_o),
    .rd_dlc_o(rd_dlc_o), .rd_data_o(rd_data_o), .msg_avail_o(msg_avail_o),
    .rx_flag_o(rx_flag_o), .empty_o(empty_o), .full_o(full_o), .count_o(count_o)
  );

  function automatic logic [28:0] id_of(logic [7:0] t);
    return {t[4:0], 16'h5A00 ^ {8'h00, t}, t};
  endfunction
  function automatic logic [3:0] dlc_of(logic [7:0] t);
    return 4'(t % 9);
  endfunction
  function automatic logic [63:0] data_of(logic [7:0] t);
    return {8{t ^ 8'hC3}};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Samples at the falling edge after the update edge.
  task automatic check_state(string req, bit exp_flag);
    chk(req, "count", 64'(count_o), 64'(m_cnt));
    chk(req, "rx_flag", 64'(rx_flag_o), 64'(exp_flag));
    chk("R9", "empty", 64'(empty_o), 64'(m_cnt == 0));
    chk("R9", "full", 64'(full_o), 64'(m_cnt == 4));
    chk("R9", "avail", 64'(msg_avail_o), 64'(m_cnt != 0));
    if (m_cnt > 0) begin
      chk(req, "head id", 64'(rd_id_o), 64'(id_of(m_tag[0])));
      chk(req, "head dlc", 64'(rd_dlc_o), 64'(dlc_of(m_tag[0])));
      chk(req, "head data", rd_data_o, data_of(m_tag[0]));
    end
  endtask

  task automatic do_op(string req, bit wr, bit pop, logic [7:0] tag);
    bit flag;
    @(negedge clk);
    wr_valid_i = wr; pop_i = pop;
    wr_id_i = id_of(tag); wr_dlc_i = dlc_of(tag); wr_data_i = data_of(tag);
    flag = 0;
    if (pop && m_cnt > 0) begin
      for (int i = 0; i < 3; i++) m_tag[i] = m_tag[i+1];
      m_cnt--;
    end
    if (wr) begin
      if (m_cnt < 4) begin m_tag[m_cnt] = tag; m_cnt++; flag = 1; end
      else if (m_ovr) begin m_tag[3] = tag; flag = 1; end
    end
    @(posedge clk); #1;
    wr_valid_i = 0; pop_i = 0;
    @(negedge clk);
    check_state(req, flag);
  endtask

  task automatic set_policy(bit load, bit v);
    @(negedge clk);
    cfg_load_i = load; cfg_ovr_i = v;
    if (load) m_ovr = v;
    @(posedge clk); #1;
    cfg_load_i = 0;
  endtask

  task automatic drain(string req);
    while (m_cnt > 0) do_op(req, 0, 1, 8'h00);
  endtask

  task automatic fill(string req, logic [7:0] base);
    for (int i = 0; i < 4; i++) do_op(req, 1, 0, base + 8'(i));
  endtask

  task automatic t_reset();
    rst_n = 0; cfg_load_i = 0; cfg_ovr_i = 0; wr_valid_i = 0; pop_i = 0;
    wr_id_i = '0; wr_dlc_i = '0; wr_data_i = '0;
    m_cnt = 0; m_ovr = 0;
    for (int i = 0; i < 4; i++) m_tag[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check_state("R1", 0);
  endtask

  task automatic t_fill_drain();
    fill("R2", 8'h10);
    drain("R4");
  endtask

  task automatic t_pop_empty();
    do_op("R5", 0, 1, 8'h00);
    do_op("R5", 0, 1, 8'h00);
  endtask

  task automatic t_drop_default();
    // Default policy after reset is drop (R1, R6).
    fill("R2", 8'h20);
    do_op("R6", 1, 0, 8'h2F);
    do_op("R6", 1, 0, 8'h2E);
    drain("R6");
  endtask

  task automatic t_overwrite();
    set_policy(1, 1);
    fill("R2", 8'h30);
    do_op("R7", 1, 0, 8'h3A);
    do_op("R7", 1, 0, 8'h3B);
    drain("R7");
  endtask

  task automatic t_policy_hold();
    // R10: value without a load strobe is ignored (still overwrite).
    set_policy(0, 0);
    fill("R10", 8'h40);
    do_op("R10", 1, 0, 8'h4A);
    drain("R10");
    set_policy(1, 0);
    fill("R10", 8'h50);
    do_op("R10", 1, 0, 8'h5A);
    set_policy(0, 1);
    do_op("R10", 1, 0, 8'h5B);
    drain("R10");
  endtask

  task automatic t_simul_full();
    set_policy(1, 0);
    fill("R2", 8'h60);
    do_op("R8", 1, 1, 8'h6A);
    set_policy(1, 1);
    do_op("R8", 1, 1, 8'h6B);
    drain("R8");
  endtask

  task automatic t_simul_mid();
    do_op("R2", 1, 0, 8'h70);
    do_op("R2", 1, 0, 8'h71);
    do_op("R11", 1, 1, 8'h72);
    do_op("R11", 1, 1, 8'h73);
    do_op("R11", 1, 1, 8'h74);
    drain("R11");
    // Write plus pop on an empty queue stores the frame.
    do_op("R11", 1, 1, 8'h75);
    drain("R4");
  endtask

  initial begin
    t_reset();
    t_fill_drain();
    t_pop_empty();
    t_drop_default();
    t_overwrite();
    t_policy_hold();
    t_simul_full();
    t_simul_mid();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule